// File: doc/BRIEF.md
# USB Endpoint Status Flag Register

This block keeps the three status flags of one endpoint of a USB 2.0 device controller. The meaning of each flag bit depends on the endpoint kind: control, bulk, interrupt, isochronous, or high-bandwidth isochronous IN. The packet engine sends single-cycle event strobes. A microframe-end strobe starts the end-of-microframe check on high-bandwidth endpoints. Firmware sends per-bit clear strobes. An endpoint reset or an endpoint disable wipes all flags.

Each flag changes on the clock edge that samples its strobe, so the `flags` output shows the new value one cycle after the strobe. The endpoint kind and direction are sampled from the configuration inputs only during chip reset or on an endpoint reset. A kind change therefore takes effect together with a full clear, and no flag is ever read under a meaning it was not set under.

Top module: `usb_ep_status_flags`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `ep_reset` or `ep_disable`, all three flags read 0 and both bank counters read 0. This clear has priority over every other input.
- R2: On a control endpoint (kind 0), `ev_setup_ok` sets bit 0 and `fw_clr[0]` clears it.
- R3: On an isochronous endpoint (kind 3) or a high-bandwidth isochronous endpoint (kind 4), `ev_txn_err` sets bit 0 and `fw_clr[0]` clears it.
- R4: On control, bulk and interrupt endpoints (kinds 0, 1, 2), `ev_stall_sent` sets bit 1 and `fw_clr[1]` clears it.
- R5: On an isochronous OUT endpoint (kind 3, `cfg_dir_in` low), each `ev_out_data` loads bit 1 with `ev_out_crc_bad`. Bit 1 keeps its value between loads, and `fw_clr[1]` has no effect on it.
- R6: On kind 4, when `uframe_end` arrives, bit 1 is set if at least one bank was sent in the closing microframe and fewer banks were validated than `cfg_ntrans`. A `cfg_ntrans` value of 0 is treated as 1. `fw_clr[1]` clears bit 1.
- R7: On kinds 0 to 3, `ev_nak_in` sets bit 2 and `fw_clr[2]` clears it.
- R8: On kind 4, when `uframe_end` arrives, bit 2 is set if more banks were validated than were sent in the closing microframe. `fw_clr[2]` clears bit 2.
- R9: The validated-bank and sent-bank counters saturate at 3. On `uframe_end`, each counter restarts at 1 if its own strobe occurs in that same cycle, and at 0 otherwise. The end-of-microframe check uses the counts from before this restart.
- R10: When a set event and a firmware clear for the same bit arrive in the same cycle, the bit ends up set.
- R11: A change of `cfg_type` or `cfg_dir_in` has no effect on the flags until the next `ep_reset`. `ep_disable` does not reload the kind.
- R12: Events that have no meaning for the active kind leave the flags unchanged. Configuration codes 5 to 7 behave as bulk (kind 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_type | input | 3 | Endpoint kind: 0 control, 1 bulk, 2 interrupt, 3 isochronous, 4 high-bandwidth isochronous IN |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_ntrans | input | 2 | Transactions per microframe (1 to 3) |
| ev_setup_ok | input | 1 | Valid SETUP packet received |
| ev_txn_err | input | 1 | Isochronous transaction error (toggle, underflow, overflow) |
| ev_stall_sent | input | 1 | Forced STALL handshake sent |
| ev_out_data | input | 1 | New OUT data received |
| ev_out_crc_bad | input | 1 | CRC status of that OUT data, 1 = corrupted |
| ev_nak_in | input | 1 | NAK returned to an IN request |
| ev_bank_valid | input | 1 | A bank was validated for transmission |
| ev_bank_sent | input | 1 | A bank was transmitted |
| uframe_end | input | 1 | Microframe-end strobe |
| fw_clr | input | 3 | Firmware clear strobes, one per flag bit |
| ep_reset | input | 1 | Endpoint reset: clears all flags and reloads the kind |
| ep_disable | input | 1 | Endpoint disable: clears all flags |
| flags | output | 3 | Status flag vector |

## Verification
Two kinds of collision can occur in one cycle. The first is a set event together with the firmware clear for the same bit. The second is a bank strobe that lands on the microframe-end strobe, where the end check must use the old counts and the new microframe must start at 1. Directed phases drive both collisions on purpose. Random phases, one per endpoint kind, produce them again at low strobe rates. A behavioural model in the bench judges every cycle: it works out each flag's next value in the order the requirements set (wipe first, then load, then set, then clear), and the bench compares its result with `flags` at every falling edge.

// File: rtl/ep_flag_pkg.sv
// Package: shared endpoint-kind encoding and flag bit positions.
// Assumes: the kind codes and bit positions are visible to firmware and must not move.
package ep_flag_pkg;

    typedef enum logic [2:0] {
        KIND_CTRL  = 3'd0,
        KIND_BULK  = 3'd1,
        KIND_INTR  = 3'd2,
        KIND_ISO   = 3'd3,
        KIND_HBISO = 3'd4
    } ep_kind_e;

    localparam int FLAG_N   = 3;
    localparam int BIT_RXEV = 0;  // setup received / error flow
    localparam int BIT_XERR = 1;  // stall sent / crc error / transaction-count error
    localparam int BIT_NAKF = 2;  // nak in / flush error

    // Map an unused configuration code onto bulk.
    function automatic ep_kind_e norm_kind(input logic [2:0] code);
        ep_kind_e k;
        case (code)
            3'd0:    k = KIND_CTRL;
            3'd2:    k = KIND_INTR;
            3'd3:    k = KIND_ISO;
            3'd4:    k = KIND_HBISO;
            default: k = KIND_BULK;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ep_bank_counter.sv
// Module: per-microframe saturating event counter.
// Counts single-cycle strobes and saturates at its maximum value. On the
// microframe-end strobe it restarts at 1 if a strobe arrives in that same
// cycle, and at 0 otherwise.
// Assumes: the reader samples cnt before the restart takes effect.
module ep_bank_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             uframe_end,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Count strobes within one microframe, restarting at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)
            cnt <= '0;
        else if (uframe_end)
            cnt <= inc ? CNT_ONE : '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + CNT_ONE;
    end

    assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uframe_end && !wipe) |=> (cnt <= CNT_ONE));
    assert_cnt_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !uframe_end && !wipe) |=> (cnt == CNT_MAX));
    assert_cnt_wipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (cnt == '0));
endmodule

// File: rtl/ep_flag_cell.sv
// Module: one status flag bit.
// Priority from highest to lowest: wipe, load, set, firmware clear.
// Because set comes before clear, a set wins over a clear in the same cycle.
// Assumes: the decoder never asserts load together with set or clear.
module ep_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic load_en,
    input  logic load_val,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Apply the priority chain to the stored bit.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)
            q <= 1'b0;
        else if (load_en)
            q <= load_val;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    assert_wipe_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> !q);
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set && clr && !wipe && !load_en) |=> q);
endmodule

// File: rtl/ep_flag_decode.sv
// Module: routes events to flag set, clear and load controls by endpoint kind.
// Also makes the end-of-microframe decision for high-bandwidth endpoints.
// Purely combinational.
// Assumes: kind and dir are the latched values; the counts come from before
// the microframe restart.
module ep_flag_decode
    import ep_flag_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  ep_kind_e             kind,
    input  logic                 dir_in,
    input  logic [CNT_W-1:0]     ntrans,
    input  logic [CNT_W-1:0]     valid_cnt,
    input  logic [CNT_W-1:0]     sent_cnt,
    input  logic                 uframe_end,
    input  logic                 ev_setup_ok,
    input  logic                 ev_txn_err,
    input  logic                 ev_stall_sent,
    input  logic                 ev_out_data,
    input  logic                 ev_out_crc_bad,
    input  logic                 ev_nak_in,
    input  logic [FLAG_N-1:0]    fw_clr,
    output logic [FLAG_N-1:0]    set,
    output logic [FLAG_N-1:0]    clr,
    output logic [FLAG_N-1:0]    load_en,
    output logic [FLAG_N-1:0]    load_val
);
    logic is_ctrl, is_hs_plain, is_iso_any, is_hb, is_iso_out;
    logic [CNT_W-1:0] nt_eff;
    logic short_frame, flushed;

    // Classify the active kind.
    always_comb begin
        is_ctrl     = (kind == KIND_CTRL);
        is_hs_plain = (kind == KIND_CTRL) || (kind == KIND_BULK) || (kind == KIND_INTR);
        is_hb       = (kind == KIND_HBISO);
        is_iso_any  = (kind == KIND_ISO) || is_hb;
        is_iso_out  = (kind == KIND_ISO) && !dir_in;
    end

    // End-of-microframe comparisons for the high-bandwidth kind.
    always_comb begin
        nt_eff      = (ntrans == '0) ? CNT_W'(1) : ntrans;
        short_frame = uframe_end && (sent_cnt != '0) && (valid_cnt < nt_eff);
        flushed     = uframe_end && (valid_cnt > sent_cnt);
    end

    // Per-bit control routing.
    always_comb begin
        set      = '0;
        clr      = '0;
        load_en  = '0;
        load_val = '0;

        set[BIT_RXEV] = (is_ctrl && ev_setup_ok) || (is_iso_any && ev_txn_err);
        clr[BIT_RXEV] = (is_ctrl || is_iso_any) && fw_clr[BIT_RXEV];

        if (is_hs_plain) begin
            set[BIT_XERR] = ev_stall_sent;
            clr[BIT_XERR] = fw_clr[BIT_XERR];
        end else if (is_hb) begin
            set[BIT_XERR] = short_frame;
            clr[BIT_XERR] = fw_clr[BIT_XERR];
        end else if (is_iso_out) begin
            load_en[BIT_XERR]  = ev_out_data;
            load_val[BIT_XERR] = ev_out_crc_bad;
        end

        if (is_hb)
            set[BIT_NAKF] = flushed;
        else
            set[BIT_NAKF] = ev_nak_in;
        clr[BIT_NAKF] = fw_clr[BIT_NAKF];
    end

    always_comb begin
        assert_load_exclusive_R5: assert ((load_en & (set | clr)) == '0);
    end
endmodule

// File: rtl/usb_ep_status_flags.sv
// Module: top level of the endpoint status flag register.
// Latches the endpoint kind and direction, counts banks per microframe,
// decodes events by kind and holds the three flag bits.
// Assumes: all strobes are single-cycle and synchronous to clk.
module usb_ep_status_flags
    import ep_flag_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_type,
    input  logic             cfg_dir_in,
    input  logic [CNT_W-1:0] cfg_ntrans,
    input  logic             ev_setup_ok,
    input  logic             ev_txn_err,
    input  logic             ev_stall_sent,
    input  logic             ev_out_data,
    input  logic             ev_out_crc_bad,
    input  logic             ev_nak_in,
    input  logic             ev_bank_valid,
    input  logic             ev_bank_sent,
    input  logic             uframe_end,
    input  logic [2:0]       fw_clr,
    input  logic             ep_reset,
    input  logic             ep_disable,
    output logic [2:0]       flags
);
    ep_kind_e         act_kind;
    logic             act_dir_in;
    logic             wipe;
    logic [CNT_W-1:0] valid_cnt, sent_cnt;
    logic [FLAG_N-1:0] f_set, f_clr, f_load_en, f_load_val;

    assign wipe = ep_reset || ep_disable;

    // Reload the endpoint kind only during chip reset or an endpoint reset.
    always_ff @(posedge clk) begin
        if (!rst_n || ep_reset) begin
            act_kind   <= norm_kind(cfg_type);
            act_dir_in <= cfg_dir_in;
        end
    end

    ep_bank_counter #(.CNT_W(CNT_W)) u_valid_cnt (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .uframe_end(uframe_end),
        .inc(ev_bank_valid), .cnt(valid_cnt)
    );

    ep_bank_counter #(.CNT_W(CNT_W)) u_sent_cnt (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .uframe_end(uframe_end),
        .inc(ev_bank_sent), .cnt(sent_cnt)
    );

    ep_flag_decode #(.CNT_W(CNT_W)) u_decode (
        .kind(act_kind), .dir_in(act_dir_in), .ntrans(cfg_ntrans),
        .valid_cnt(valid_cnt), .sent_cnt(sent_cnt), .uframe_end(uframe_end),
        .ev_setup_ok(ev_setup_ok), .ev_txn_err(ev_txn_err),
        .ev_stall_sent(ev_stall_sent), .ev_out_data(ev_out_data),
        .ev_out_crc_bad(ev_out_crc_bad), .ev_nak_in(ev_nak_in),
        .fw_clr(fw_clr), .set(f_set), .clr(f_clr),
        .load_en(f_load_en), .load_val(f_load_val)
    );

    for (genvar b = 0; b < FLAG_N; b++) begin : g_flag
        ep_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n), .wipe(wipe),
            .load_en(f_load_en[b]), .load_val(f_load_val[b]),
            .set(f_set[b]), .clr(f_clr[b]), .q(flags[b])
        );
    end

    assert_no_rxev_on_bulk_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (act_kind == KIND_BULK || act_kind == KIND_INTR) |-> !flags[BIT_RXEV]);
    assert_no_xerr_on_iso_in_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (act_kind == KIND_ISO && act_dir_in) |-> !flags[BIT_XERR]);
    assert_crc_follows_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_kind == KIND_ISO && !act_dir_in && ev_out_data && !wipe)
        |=> (flags[BIT_XERR] == $past(ev_out_crc_bad)));
    assert_kind_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_reset |=> (act_kind == $past(act_kind)));
endmodule

// File: tb/usb_ep_status_flags_bench.sv
module usb_ep_status_flags_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic [2:0] cfg_type;
    logic cfg_dir_in;
    logic [1:0] cfg_ntrans;
    logic ev_setup_ok, ev_txn_err, ev_stall_sent, ev_out_data, ev_out_crc_bad;
    logic ev_nak_in, ev_bank_valid, ev_bank_sent, uframe_end;
    logic [2:0] fw_clr;
    logic ep_reset, ep_disable;
    logic [2:0] flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_kind, m_dir, m_valid, m_sent;
    bit [2:0] m_flags;

    always #4 clk = ~clk;

    usb_ep_status_flags u_usb_ep_status_flags (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_dir_in(cfg_dir_in),
        .cfg_ntrans(cfg_ntrans), .ev_setup_ok(ev_setup_ok), .ev_txn_err(ev_txn_err),
        .ev_stall_sent(ev_stall_sent), .ev_out_data(ev_out_data),
        .ev_out_crc_bad(ev_out_crc_bad), .ev_nak_in(ev_nak_in),
        .ev_bank_valid(ev_bank_valid), .ev_bank_sent(ev_bank_sent),
        .uframe_end(uframe_end), .fw_clr(fw_clr), .ep_reset(ep_reset),
        .ep_disable(ep_disable), .flags(flags)
    );

    // Behavioural reference: next state from current inputs, requirement by requirement.
    task automatic model_edge();
        int nt;
        bit [2:0] nf;
        nf = m_flags;
        if (!rst_n || ep_reset) begin
            m_kind = (cfg_type <= 4 && cfg_type != 1) ? int'(cfg_type) : 1;  // R11, R12
            m_dir  = int'(cfg_dir_in);
        end
        if (!rst_n || ep_reset || ep_disable) begin  // R1
            m_flags = 3'b000; m_valid = 0; m_sent = 0;
            return;
        end
        nt = (cfg_ntrans == 0) ? 1 : int'(cfg_ntrans);
        // bit 0
        if ((m_kind == 0 && ev_setup_ok) || (m_kind >= 3 && ev_txn_err)) nf[0] = 1;       // R2 R3
        else if (m_kind != 1 && m_kind != 2 && fw_clr[0]) nf[0] = 0;
        // bit 1
        if (m_kind <= 2) begin                                                              // R4
            if (ev_stall_sent) nf[1] = 1; else if (fw_clr[1]) nf[1] = 0;
        end else if (m_kind == 4) begin                                                     // R6
            if (uframe_end && m_sent >= 1 && m_valid < nt) nf[1] = 1;
            else if (fw_clr[1]) nf[1] = 0;
        end else if (m_dir == 0) begin                                                      // R5
            if (ev_out_data) nf[1] = ev_out_crc_bad;
        end
        // bit 2
        if (m_kind == 4) begin                                                              // R8
            if (uframe_end && m_valid > m_sent) nf[2] = 1; else if (fw_clr[2]) nf[2] = 0;
        end else begin                                                                      // R7
            if (ev_nak_in) nf[2] = 1; else if (fw_clr[2]) nf[2] = 0;
        end
        m_flags = nf;
        // counters, R9
        if (uframe_end) begin
            m_valid = ev_bank_valid ? 1 : 0;
            m_sent  = ev_bank_sent ? 1 : 0;
        end else begin
            if (ev_bank_valid && m_valid < 3) m_valid++;
            if (ev_bank_sent && m_sent < 3) m_sent++;
        end
    endtask

    task automatic idle();
        ev_setup_ok = 0; ev_txn_err = 0; ev_stall_sent = 0; ev_out_data = 0;
        ev_out_crc_bad = 0; ev_nak_in = 0; ev_bank_valid = 0; ev_bank_sent = 0;
        uframe_end = 0; fw_clr = 3'b000; ep_reset = 0; ep_disable = 0;
    endtask

    // One clock: model the edge, then compare at the falling edge and clear strobes.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (flags !== m_flags) begin
            errors++;
            $display("FAIL %s: flags actual %b expected %b at %0t", cur_req, flags, m_flags, $time);
        end
        idle();
    endtask

    task automatic select_kind(input int k, input bit din, input int nt);
        cfg_type = 3'(k); cfg_dir_in = din; cfg_ntrans = 2'(nt);
        ep_reset = 1; step();
    endtask

    task automatic random_run(input int k, input bit din, input int n);
        select_kind(k, din, 1 + ($urandom % 3));
        for (int i = 0; i < n; i++) begin
            ev_setup_ok    = ($urandom % 6) == 0;
            ev_txn_err     = ($urandom % 6) == 0;
            ev_stall_sent  = ($urandom % 6) == 0;
            ev_out_data    = ($urandom % 4) == 0;
            ev_out_crc_bad = ($urandom % 2) == 0;
            ev_nak_in      = ($urandom % 6) == 0;
            ev_bank_valid  = ($urandom % 3) == 0;
            ev_bank_sent   = ($urandom % 3) == 0;
            uframe_end     = ($urandom % 7) == 0;
            fw_clr         = 3'($urandom % 8) & {3{($urandom % 3) == 0}};
            ep_disable     = ($urandom % 50) == 0;
            cfg_type       = 3'($urandom % 8);   // R11: must not take effect
            cfg_dir_in     = 1'($urandom % 2);
            step();
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        cfg_type = 0; cfg_dir_in = 0; cfg_ntrans = 2'd2;
        rst_n = 0;
        @(negedge clk);
        step(); step();
        rst_n = 1;
        cur_req = "R1"; step();

        // R2: setup sets, clear clears, then R10 collision
        cur_req = "R2"; ev_setup_ok = 1; step();
        fw_clr = 3'b001; step();
        cur_req = "R10"; ev_setup_ok = 1; fw_clr = 3'b001; step();
        // R4 stall, R7 nak on control
        cur_req = "R4"; ev_stall_sent = 1; step();
        fw_clr = 3'b010; step();
        cur_req = "R7"; ev_nak_in = 1; step();
        cur_req = "R10"; ev_nak_in = 1; fw_clr = 3'b100; step();
        // R11: kind change without reset is ignored
        cur_req = "R11"; cfg_type = 3'd1; ev_setup_ok = 1; step();
        // R1: disable wipes, and does not reload the kind
        cur_req = "R1"; ep_disable = 1; ev_setup_ok = 1; step();
        cur_req = "R11"; ev_setup_ok = 1; step();
        // R12: bulk ignores setup and txn errors; code 6 is bulk
        cur_req = "R12"; select_kind(6, 1, 1);
        ev_setup_ok = 1; ev_txn_err = 1; step();
        // R3 and R5 on iso OUT
        cur_req = "R3"; select_kind(3, 0, 1);
        ev_txn_err = 1; step();
        cur_req = "R5"; ev_out_data = 1; ev_out_crc_bad = 1; step();
        fw_clr = 3'b010; step();
        ev_out_data = 1; ev_out_crc_bad = 0; step();
        // R6 / R8 / R9 on high-bandwidth iso IN, ntrans 3
        cur_req = "R6"; select_kind(4, 1, 3);
        ev_bank_valid = 1; ev_bank_sent = 1; step();
        uframe_end = 1; step();
        fw_clr = 3'b010; step();
        cur_req = "R8"; ev_bank_valid = 1; step();
        ev_bank_valid = 1; step();
        ev_bank_valid = 1; ev_bank_sent = 1; step();
        cur_req = "R9"; ev_bank_valid = 1; ev_bank_sent = 1; uframe_end = 1; step();
        uframe_end = 1; step();
        cur_req = "R6"; cfg_ntrans = 2'd0; ev_bank_valid = 1; ev_bank_sent = 1; step();
        uframe_end = 1; step();
        cur_req = "R9"; ev_bank_valid = 1; step(); ev_bank_valid = 1; step();
        ev_bank_valid = 1; step(); ev_bank_valid = 1; step();
        uframe_end = 1; step();

        // random phases per kind
        cur_req = "R12";
        for (int k = 0; k < 8; k++) begin
            random_run(k, 1'b0, 150);
            random_run(k, 1'b1, 150);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule